// File: doc/BRIEF.md
# Serial console line assembler

This block sits behind a debug serial transmit register and turns the stream of characters that software writes there into whole text lines. Each write carries either one character or a 32-bit word. A word is unpacked into four characters, taken from the least significant byte upward. The characters are gathered in a line buffer until a line is complete. The completed line then leaves on a byte stream with valid, data, last and ready signals.

Line endings are normalised on the way in. A carriage return becomes a newline. Any newline that arrives while the most recent stored character came from a carriage return is dropped, so a CR/LF pair yields a single newline. A line is complete when a newline has been stored, or when the buffer holds its capacity less one character.

While a line is being streamed out, the write side is held off. The stream never carries an empty line.

Top module: `conlog_assembler`

## Requirements
- R1: After synchronous reset, wr_ready is 1 and out_valid is 0.
- R2: With wr_wide=1, wr_data is entered as four characters in the order bits 7:0, 15:8, 23:16, 31:24. With wr_wide=0, only bits 7:0 are entered, as one character.
- R3: A carriage return (0x0D) is stored as a newline (0x0A) and completes the line.
- R4: A newline (0x0A) is dropped while the most recently stored character came from a carriage return. A dropped newline leaves that condition set. Storing any other character clears it.
- R5: Storing a newline (0x0A) completes the line, and the newline is its final character.
- R6: When BUF_DEPTH-1 characters have been stored with no newline among them, the line completes at that length.
- R7: A completed line leaves in order, one character per accepted transfer, with out_last=1 on the final character only. While out_ready=0, out_data and out_last hold steady.
- R8: wr_ready is 0 whenever out_valid is 1.
- R9: No line of zero characters is ever emitted. In particular, a dropped newline on an empty buffer produces no output.
- R10: After a line has been streamed, collection restarts from an empty buffer, so no character appears in two lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Register write present |
| wr_wide | input | 1 | 1: 32-bit write, 0: 8-bit write |
| wr_data | input | 8*WORD_BYTES | Write data; only bits 7:0 are used when wr_wide=0 |
| wr_ready | output | 1 | Write accepted this cycle when high together with wr_valid |
| out_valid | output | 1 | Line character available |
| out_data | output | 8 | Line character |
| out_last | output | 1 | Final character of the line |
| out_ready | input | 1 | Downstream takes the character |

## Verification
A stuck carriage-return flag shows up on the next newline that should survive. That newline either vanishes or appears twice, and the difference is visible within one line of output. A wrong fill count moves the forced break away from BUF_DEPTH-1 characters, or lets a character leak into the following line. Either fault changes the boundary of the very next line emitted. A read pointer or phase fault corrupts the streamed bytes or the out_last position as soon as the line drains. Because the reference model compares every transfer as it happens, each of these faults is reported in the cycle where it first reaches the ports.

// File: rtl/conlog_pkg.sv
package conlog_pkg;

    localparam logic [7:0] CH_CR = 8'h0D;
    localparam logic [7:0] CH_LF = 8'h0A;

    typedef enum logic {
        PH_FILL  = 1'b0,
        PH_DRAIN = 1'b1
    } phase_e;

    // Result of passing one incoming character through the line-ending rules
    typedef struct packed {
        logic       keep;      // character is stored
        logic [7:0] ch;        // character to store
        logic       is_eol;    // stored character ends the line
        logic       cr_next;   // next value of the carriage-return flag
    } norm_t;

    function automatic norm_t normalise(input logic [7:0] b, input logic cr_seen);
        norm_t r;
        r.keep    = 1'b1;
        r.ch      = b;
        r.is_eol  = 1'b0;
        r.cr_next = 1'b0;
        if (b == CH_CR) begin
            r.ch      = CH_LF;
            r.is_eol  = 1'b1;
            r.cr_next = 1'b1;
        end else if (b == CH_LF) begin
            if (cr_seen) begin
                r.keep    = 1'b0;
                r.cr_next = 1'b1;
            end else begin
                r.is_eol  = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/conlog_split.sv
module conlog_split #(
    parameter int WORD_BYTES = 4,
    localparam int CNT_W = $clog2(WORD_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    in_valid,
    input  logic                    in_wide,
    input  logic [8*WORD_BYTES-1:0] in_data,
    output logic                    in_ready,
    output logic                    byte_valid,
    output logic [7:0]              byte_data,
    input  logic                    byte_ready
);

    logic [WORD_BYTES-1:0][7:0] hold;
    logic [CNT_W-1:0]           left;

    assign in_ready   = (left == '0) && en;
    assign byte_valid = (left != '0);
    assign byte_data  = hold[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
            hold <= '0;
        end else if (in_valid && in_ready) begin
            hold <= in_data;
            left <= in_wide ? CNT_W'(WORD_BYTES) : CNT_W'(1);
        end else if (byte_valid && byte_ready) begin
            for (int i = 0; i < WORD_BYTES - 1; i++) begin
                hold[i] <= hold[i+1];
            end
            hold[WORD_BYTES-1] <= '0;
            left <= left - CNT_W'(1);
        end
    end

endmodule

// File: rtl/conlog_norm.sv
module conlog_norm
    import conlog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_take,
    output logic       st_valid,
    output logic [7:0] st_data,
    output logic       st_eol
);

    logic  cr_seen;
    norm_t n;

    always_comb begin
        n        = normalise(in_data, cr_seen);
        st_valid = in_valid && in_take && n.keep;
        st_data  = n.ch;
        st_eol   = n.is_eol;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cr_seen <= 1'b0;
        end else if (in_valid && in_take) begin
            cr_seen <= n.cr_next;
        end
    end

endmodule

// File: rtl/conlog_linebuf.sv
module conlog_linebuf
    import conlog_pkg::*;
#(
    parameter int BUF_DEPTH = 1024,
    localparam int PTR_W = $clog2(BUF_DEPTH)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       st_valid,
    input  logic [7:0] st_data,
    input  logic       st_eol,
    output logic       fill,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last,
    input  logic       out_ready
);

    logic [7:0]       mem [BUF_DEPTH];
    logic [PTR_W-1:0] wcnt;
    logic [PTR_W-1:0] last_idx;
    logic [PTR_W-1:0] rd;
    phase_e           phase;
    logic             store;
    logic             full_now;

    assign fill      = (phase == PH_FILL);
    assign store     = st_valid && fill;
    assign full_now  = (wcnt == PTR_W'(BUF_DEPTH - 2));
    assign out_valid = (phase == PH_DRAIN);
    assign out_data  = mem[rd];
    assign out_last  = (rd == last_idx);

    always_ff @(posedge clk) begin
        if (store) begin
            mem[wcnt] <= st_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_FILL;
            wcnt     <= '0;
            last_idx <= '0;
            rd       <= '0;
        end else if (store) begin
            if (st_eol || full_now) begin
                phase    <= PH_DRAIN;
                last_idx <= wcnt;
                rd       <= '0;
                wcnt     <= '0;
            end else begin
                wcnt <= wcnt + PTR_W'(1);
            end
        end else if (out_valid && out_ready) begin
            if (out_last) begin
                phase <= PH_FILL;
            end else begin
                rd <= rd + PTR_W'(1);
            end
        end
    end

endmodule

// File: rtl/conlog_assembler.sv
module conlog_assembler
    import conlog_pkg::*;
#(
    parameter int BUF_DEPTH  = 1024,
    parameter int WORD_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_valid,
    input  logic                    wr_wide,
    input  logic [8*WORD_BYTES-1:0] wr_data,
    output logic                    wr_ready,
    output logic                    out_valid,
    output logic [7:0]              out_data,
    output logic                    out_last,
    input  logic                    out_ready
);

    logic       fill;
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       st_valid;
    logic [7:0] st_data;
    logic       st_eol;

    conlog_split #(.WORD_BYTES(WORD_BYTES)) u_split (
        .clk        (clk),
        .rst        (rst),
        .en         (fill),
        .in_valid   (wr_valid),
        .in_wide    (wr_wide),
        .in_data    (wr_data),
        .in_ready   (wr_ready),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .byte_ready (fill)
    );

    conlog_norm u_norm (
        .clk      (clk),
        .rst      (rst),
        .in_valid (byte_valid),
        .in_data  (byte_data),
        .in_take  (fill),
        .st_valid (st_valid),
        .st_data  (st_data),
        .st_eol   (st_eol)
    );

    conlog_linebuf #(.BUF_DEPTH(BUF_DEPTH)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .st_valid  (st_valid),
        .st_data   (st_data),
        .st_eol    (st_eol),
        .fill      (fill),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last),
        .out_ready (out_ready)
    );

endmodule

// File: rtl/conlog_assembler_chk.sv
module conlog_assembler_chk
    import conlog_pkg::*;
#(
    parameter int BUF_DEPTH = 1024
) (
    input logic       clk,
    input logic       rst,
    input logic       wr_ready,
    input logic       out_valid,
    input logic [7:0] out_data,
    input logic       out_last,
    input logic       out_ready
);

    int unsigned sent;

    always_ff @(posedge clk) begin
        if (rst) begin
            sent <= 0;
        end else if (out_valid && out_ready) begin
            sent <= out_last ? 0 : sent + 1;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (wr_ready && !out_valid)); // R1

    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R7

    AST_NO_WRITE_IN_FLUSH: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !wr_ready); // R8

    AST_LF_ONLY_LAST: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |-> (out_data != CH_LF)); // R5

    AST_CAPACITY_BREAK: assert property (@(posedge clk) disable iff (rst)
        (out_valid && sent == BUF_DEPTH - 2) |-> out_last); // R6

endmodule

bind conlog_assembler conlog_assembler_chk #(.BUF_DEPTH(BUF_DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_ready  (wr_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_ready (out_ready)
);

// File: tb/conlog_assembler_test.sv
module conlog_assembler_test;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic        wr_wide = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_last;
    logic        out_ready = 1'b1;

    always #2 clk = ~clk;

    conlog_assembler #(.BUF_DEPTH(DEPTH), .WORD_BYTES(4)) uut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_wide(wr_wide),
        .wr_data(wr_data), .wr_ready(wr_ready), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last), .out_ready(out_ready)
    );

    int    vectors = 0;
    int    errors  = 0;
    string cur_req = "R1";
    int    ready_mode = 0;
    bit    running = 1'b0;
    bit    done = 1'b0;

    // behavioural reference: pending characters and expected stream
    bit         m_cr = 1'b0;
    logic [7:0] m_line[$];
    logic [8:0] exp_q[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_char(input logic [7:0] b);
        logic [7:0] c;
        c = b;
        if (b == 8'h0D) begin
            c = 8'h0A;
            m_cr = 1'b1;
        end else if (b == 8'h0A && m_cr) begin
            return;
        end else begin
            m_cr = 1'b0;
        end
        m_line.push_back(c);
        if (c == 8'h0A || m_line.size() == DEPTH - 1) begin
            foreach (m_line[i]) exp_q.push_back({(i == m_line.size() - 1), m_line[i]});
            m_line.delete();
        end
    endtask

    task automatic wr(input bit wide, input logic [31:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_wide  = wide;
        wr_data  = d;
        while (!wr_ready) @(negedge clk);
        @(posedge clk);
        if (wide) begin
            for (int k = 0; k < 4; k++) model_char(d[8*k +: 8]);
        end else begin
            model_char(d[7:0]);
        end
        @(negedge clk);
        wr_valid = 1'b0;
        wr_data  = 32'hDEAD_BEEF;
    endtask

    task automatic wr_str(input string s);
        for (int i = 0; i < s.len(); i++) wr(1'b0, {24'h0, s[i]});
    endtask

    task automatic drain();
        int n;
        n = 0;
        while ((exp_q.size() != 0 || out_valid) && n < 2000) begin
            @(negedge clk);
            n++;
        end
        repeat (4) @(negedge clk);
    endtask

    // monitor: choose ready, compare every transfer, watch the write side
    initial begin
        logic [7:0] prev_d;
        logic       prev_l;
        bit         stalled;
        logic [8:0] e;
        stalled = 1'b0;
        prev_d  = '0;
        prev_l  = 1'b0;
        forever begin
            @(negedge clk);
            if (running) begin
                if (stalled) begin
                    check(out_valid && out_data == prev_d && out_last == prev_l, "R7",
                          {out_valid, out_last, out_data}, {1'b1, prev_l, prev_d});
                end
                out_ready = (ready_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
                if (out_valid) check(!wr_ready, "R8", wr_ready, 0);
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, {cur_req, " (R9 unexpected output)"}, {out_last, out_data}, 0);
                    end else begin
                        e = exp_q.pop_front();
                        check({out_last, out_data} == e, cur_req, {out_last, out_data}, e);
                    end
                end
                stalled = out_valid && !out_ready;
                prev_d  = out_data;
                prev_l  = out_last;
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(wr_ready == 1'b1 && out_valid == 1'b0, "R1", {wr_ready, out_valid}, 2'b10);
        running = 1'b1;

        cur_req = "R5";
        wr_str("hi\n");
        drain();

        cur_req = "R2";
        wr(1'b1, 32'h0A43_4241);
        drain();
        wr(1'b1, 32'h4443_4241);
        wr(1'b0, 32'hFFFF_FF0A);
        drain();

        cur_req = "R3";
        wr_str("ok\r");
        drain();

        cur_req = "R4";
        wr_str("x\r\nY\n");
        wr_str("a\r\n\nb\n");
        wr_str("\r\r");
        wr(1'b1, 32'h0A0D_0A0D);
        drain();

        cur_req = "R9";
        wr_str("q\r");
        drain();
        wr_str("\n\n");
        repeat (10) @(negedge clk);
        check(out_valid == 1'b0 && exp_q.size() == 0, "R9", out_valid, 0);

        cur_req = "R6";
        for (int i = 0; i < 20; i++) wr(1'b0, 32'h61 + i);
        drain();
        cur_req = "R10";
        wr_str("\n");
        drain();

        cur_req = "R7";
        ready_mode = 1;
        for (int i = 0; i < 300; i++) begin
            logic [31:0] w;
            for (int k = 0; k < 4; k++) begin
                int r;
                r = $urandom % 8;
                w[8*k +: 8] = (r == 0) ? 8'h0D : (r == 1) ? 8'h0A : 8'(8'h61 + ($urandom % 26));
            end
            wr(($urandom % 2) == 0, w);
        end
        wr_str("\n");
        drain();

        check(exp_q.size() == 0, "R10", exp_q.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule